// File: doc/BRIEF.md
# Gap-Tagged ADC Stream Framer

The framer sits between a source of 14-bit ADC samples and a bounded output FIFO during continuous readout. Each sample it accepts is written to the FIFO as a 16-bit word whose two top bits form a word-type tag. When the FIFO cannot take a sample, the sample is discarded. A saturating loss counter records the discarded sample, and a register keeps the channel number of the most recent one.

When the FIFO has room again, the framer writes an in-band marker of three tagged error words before any further data. The marker holds the loss count and the last lost channel. The host can size the gap from this and realign its channel sequence. A separate stop input halts acquisition at once. While stop is high, no sample is written and no loss is counted, but a pending marker is still flushed.

The FIFO write strobe is combinational. It is qualified in the same cycle by the FIFO full flag, so no word is ever offered to a full FIFO. All state sits behind an asynchronous active-low reset whose release is synchronised to the clock.

Top module: `gap_framer`

## Requirements
- R1: With no marker pending, stop low and the FIFO not full, a valid sample is written in the same cycle as the word {2'b00, sample[13:0]}.
- R2: A valid sample that arrives while stop is low and the FIFO is full is not written. It adds one to the loss count, and its channel becomes the stored channel.
- R3: After a loss, the marker words are written in order, first tag 01, then tag 10, then tag 11. Each word is written only in a cycle where the FIFO is not full, and a full cycle holds the current word. While the marker is pending, samples are not written.
- R4: Marker fields: the tag 01 word carries count bits 37..24 in bits 13..0. The tag 10 word carries count bits 23..10 in bits 13..0. The tag 11 word carries count bits 9..0 in bits 13..4 and the 4-bit channel in bits 3..0.
- R5: Once the tag 11 word is written, the loss count and the stored channel return to zero. The next sample is then written as data, and a later marker reports only the losses after that point.
- R6: A valid sample that arrives while a marker is pending, with stop low, counts as lost whether the FIFO is full or not. It updates the stored channel, and the marker restarts at the tag 01 word with the updated count.
- R7: The loss count saturates at its all-ones value and does not wrap.
- R8: While stop is high, no sample is written and no loss is counted. A pending marker is still written out under the rules of R3.
- R9: After reset, no write occurs until a sample arrives, and no marker is pending: the first sample passes as a data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | A sample is present this cycle |
| smp_data_i | input | 14 | Sample value |
| smp_chan_i | input | 4 | Channel number of the sample |
| stop_i | input | 1 | Acquisition halt; high blocks sample writes and loss counting |
| fifo_full_i | input | 1 | Output FIFO cannot accept a word this cycle |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 16 | Word to write: 2-bit tag and 14-bit payload |

## Verification
The write strobe and the word are combinational. The bench therefore drives inputs just after a falling edge and checks the outputs two nanoseconds later, in the same cycle, before the next rising edge. Loss counting, stored channel and marker position change at the rising edge. Their effect shows in the outputs of the following cycle: the first marker word appears in the first cycle after a loss in which the FIFO is not full. Reset release goes through a two-stage synchroniser, so the bench waits three cycles after raising reset before its first check.

// File: rtl/gap_framer_pkg.sv
package gap_framer_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned TAG_W     = 2;
  localparam int unsigned PAYLOAD_W = WORD_W - TAG_W;

  typedef enum logic [TAG_W-1:0] {
    TAG_DATA    = 2'b00,
    TAG_ERR_HI  = 2'b01,
    TAG_ERR_MID = 2'b10,
    TAG_ERR_LO  = 2'b11
  } word_tag_e;

  typedef enum logic [1:0] {
    SEG_HI  = 2'd0,
    SEG_MID = 2'd1,
    SEG_LO  = 2'd2
  } seg_e;

  typedef struct packed {
    word_tag_e            tag;
    logic [PAYLOAD_W-1:0] payload;
  } fifo_word_t;

endpackage

// File: rtl/gf_rst_sync.sv
module gf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/gf_loss_tracker.sv
module gf_loss_tracker #(
  parameter int unsigned CNT_W = 38,
  parameter int unsigned CH_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lose_i,
  input  logic             clear_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CH_W-1:0]  chan_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    chan_d = chan_q;
    upd_en = lose_i | clear_i;
    if (lose_i) begin
      chan_d = chan_i;
      if (clear_i) begin
        cnt_d = CNT_ONE;
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end else if (clear_i) begin
      cnt_d  = '0;
      chan_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      chan_q <= '0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      chan_q <= chan_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign chan_o = chan_q;

endmodule

// File: rtl/gf_marker_seq.sv
module gf_marker_seq
  import gap_framer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lose_i,
  input  logic space_i,
  output logic pending_o,
  output logic emit_o,
  output logic last_o,
  output seg_e seg_o
);

  logic pend_q, pend_d;
  seg_e seg_q, seg_d;
  logic emit, last, seq_en;

  always_comb begin
    emit   = pend_q & space_i;
    last   = emit & (seg_q == SEG_LO);
    pend_d = pend_q;
    seg_d  = seg_q;
    seq_en = lose_i | emit;
    if (lose_i) begin
      pend_d = 1'b1;
      seg_d  = SEG_HI;
    end else if (last) begin
      pend_d = 1'b0;
      seg_d  = SEG_HI;
    end else if (emit) begin
      seg_d  = (seg_q == SEG_HI) ? SEG_MID : SEG_LO;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      seg_q  <= SEG_HI;
    end else if (seq_en) begin
      pend_q <= pend_d;
      seg_q  <= seg_d;
    end
  end

  assign pending_o = pend_q;
  assign emit_o    = emit;
  assign last_o    = last;
  assign seg_o     = seg_q;

endmodule

// File: rtl/gf_word_build.sv
module gf_word_build
  import gap_framer_pkg::*;
#(
  parameter int unsigned HI_W  = 14,
  parameter int unsigned MID_W = 14,
  parameter int unsigned LO_W  = 10,
  parameter int unsigned CH_W  = 4,
  localparam int unsigned CNT_W = HI_W + MID_W + LO_W
) (
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [CH_W-1:0]      chan_i,
  input  seg_e                 seg_i,
  input  logic                 marker_i,
  input  logic [PAYLOAD_W-1:0] smp_i,
  output fifo_word_t           word_o
);

  localparam int unsigned MID_LSB = LO_W;
  localparam int unsigned HI_LSB  = LO_W + MID_W;

  logic [PAYLOAD_W-1:0] f_hi, f_mid, f_lo;

  always_comb begin
    f_hi  = '0;
    f_mid = '0;
    f_lo  = '0;
    f_hi[HI_W-1:0]       = cnt_i[HI_LSB +: HI_W];
    f_mid[MID_W-1:0]     = cnt_i[MID_LSB +: MID_W];
    f_lo[CH_W +: LO_W]   = cnt_i[0 +: LO_W];
    f_lo[CH_W-1:0]       = chan_i;
  end

  always_comb begin
    word_o.tag     = TAG_DATA;
    word_o.payload = smp_i;
    if (marker_i) begin
      unique case (seg_i)
        SEG_HI:  begin word_o.tag = TAG_ERR_HI;  word_o.payload = f_hi;  end
        SEG_MID: begin word_o.tag = TAG_ERR_MID; word_o.payload = f_mid; end
        default: begin word_o.tag = TAG_ERR_LO;  word_o.payload = f_lo;  end
      endcase
    end
  end

endmodule

// File: rtl/gap_framer.sv
module gap_framer
  import gap_framer_pkg::*;
#(
  parameter int unsigned HI_W   = 14,
  parameter int unsigned MID_W  = 14,
  parameter int unsigned LO_W   = 10,
  parameter int unsigned CH_W   = 4,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned CNT_W = HI_W + MID_W + LO_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_valid_i,
  input  logic [PAYLOAD_W-1:0] smp_data_i,
  input  logic [CH_W-1:0]      smp_chan_i,
  input  logic                 stop_i,
  input  logic                 fifo_full_i,
  output logic                 wr_en_o,
  output logic [WORD_W-1:0]    wr_data_o
);

  logic             rst_int_n;
  logic             take, lose, pass;
  logic             mark_pend, mark_emit, mark_last;
  seg_e             mark_seg;
  logic [CNT_W-1:0] loss_cnt;
  logic [CH_W-1:0]  loss_chan;
  fifo_word_t       word;

  gf_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  always_comb begin
    take = smp_valid_i & ~stop_i;
    lose = take & (mark_pend | fifo_full_i);
    pass = take & ~mark_pend & ~fifo_full_i;
  end

  gf_marker_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .lose_i    (lose),
    .space_i   (~fifo_full_i),
    .pending_o (mark_pend),
    .emit_o    (mark_emit),
    .last_o    (mark_last),
    .seg_o     (mark_seg)
  );

  gf_loss_tracker #(.CNT_W(CNT_W), .CH_W(CH_W)) u_loss (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .lose_i  (lose),
    .clear_i (mark_last),
    .chan_i  (smp_chan_i),
    .cnt_o   (loss_cnt),
    .chan_o  (loss_chan)
  );

  gf_word_build #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W), .CH_W(CH_W)) u_build (
    .cnt_i    (loss_cnt),
    .chan_i   (loss_chan),
    .seg_i    (mark_seg),
    .marker_i (mark_pend),
    .smp_i    (smp_data_i),
    .word_o   (word)
  );

  assign wr_en_o   = mark_emit | pass;
  assign wr_data_o = word;

endmodule

// File: rtl/gap_framer_checker.sv
module gap_framer_checker #(
  parameter int unsigned CNT_W = 38
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic [13:0]      smp_data_i,
  input logic             stop_i,
  input logic             fifo_full_i,
  input logic             wr_en_o,
  input logic [15:0]      wr_data_o,
  input logic [CNT_W-1:0] loss_cnt,
  input logic             mark_pend
);

  logic [1:0] last_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_tag_q <= 2'b11;
    end else if (wr_en_o) begin
      last_tag_q <= wr_data_o[15:14];
    end
  end

  p_no_write_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !wr_en_o);

  p_data_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[15:14] == 2'b00) |->
      (smp_valid_i && !stop_i && wr_data_o[13:0] == smp_data_i));

  p_marker_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[15:14] == 2'b10) |-> (last_tag_q == 2'b01));

  p_marker_tail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[15:14] == 2'b11) |-> (last_tag_q == 2'b10));

  p_stop_no_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wr_en_o) |-> (wr_data_o[15:14] != 2'b00));

  p_idle_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mark_pend |-> (loss_cnt == '0));

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_cnt != '0) |=> ((loss_cnt == '0) || (loss_cnt == CNT_W'(1)) ||
                          (loss_cnt >= $past(loss_cnt))));

endmodule

bind gap_framer gap_framer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_data_i  (smp_data_i),
  .stop_i      (stop_i),
  .fifo_full_i (fifo_full_i),
  .wr_en_o     (wr_en_o),
  .wr_data_o   (wr_data_o),
  .loss_cnt    (loss_cnt),
  .mark_pend   (mark_pend)
);

// File: tb/gap_framer_bench.sv
module gap_framer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, stop, full;
  logic [13:0] data;
  logic [3:0]  chan;
  logic        wr_en, wr_en_s;
  logic [15:0] wr_data, wr_data_s;
  int          n_run = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  gap_framer u_gap_framer (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_data_i(data),
    .smp_chan_i(chan), .stop_i(stop), .fifo_full_i(full),
    .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  gap_framer #(.HI_W(2), .MID_W(2), .LO_W(2)) u_gap_framer_sat (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_data_i(data),
    .smp_chan_i(chan), .stop_i(stop), .fifo_full_i(full),
    .wr_en_o(wr_en_s), .wr_data_o(wr_data_s)
  );

  task automatic put(input logic v, input logic [13:0] d, input logic [3:0] c,
                     input logic f, input logic s);
    valid = v; data = d; chan = c; full = f; stop = s;
    #2;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic en, input logic [15:0] exp);
    n_run++;
    if (wr_en !== en || (en && wr_data !== exp)) begin
      n_fail++;
      $display("FAIL %s: got en=%b data=%h, expected en=%b data=%h",
               req, wr_en, wr_data, en, exp);
    end
  endtask

  task automatic chk_s(input string req, input logic [15:0] exp);
    n_run++;
    if (wr_en_s !== 1'b1 || wr_data_s !== exp) begin
      n_fail++;
      $display("FAIL %s (narrow): got en=%b data=%h, expected en=1 data=%h",
               req, wr_en_s, wr_data_s, exp);
    end
  endtask

  task automatic lose_n(input int n, input logic [3:0] c);
    for (int i = 0; i < n; i++) begin
      put(1'b1, 14'(i), c, 1'b1, 1'b0);
      if (i == 0) chk("R2 drop while full", 1'b0, 16'h0);
      nxt();
    end
  endtask

  task automatic t_reset();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0);
    chk("R9 idle after reset", 1'b0, 16'h0);
    nxt();
    put(1'b1, 14'h0155, 4'h1, 1'b0, 1'b0);
    chk("R9 first sample is data", 1'b1, 16'h0155);
    nxt();
  endtask

  task automatic t_pass();
    put(1'b1, 14'h3FFF, 4'h2, 1'b0, 1'b0); chk("R1 data all ones", 1'b1, 16'h3FFF); nxt();
    put(1'b1, 14'h0001, 4'h3, 1'b0, 1'b0); chk("R1 data one", 1'b1, 16'h0001); nxt();
    put(1'b0, 14'h1234, 4'h3, 1'b0, 1'b0); chk("R1 no valid no write", 1'b0, 16'h0); nxt();
  endtask

  task automatic t_basic_gap();
    lose_n(3, 4'h7);
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R3 word tag 01", 1'b1, 16'h4000); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R3 word tag 10", 1'b1, 16'h8000); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R4 word tag 11 count 3 chan 7", 1'b1, 16'hC037); nxt();
    put(1'b1, 14'h0222, 4'h0, 1'b0, 1'b0); chk("R5 data resumes", 1'b1, 16'h0222); nxt();
    lose_n(1, 4'h4);
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R5 count cleared, only new loss", 1'b1, 16'hC014); nxt();
  endtask

  task automatic t_fields();
    lose_n(9, 4'h5);
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk_s("R4 nine: hi field", 16'h4000); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk_s("R4 nine: mid field", 16'h8002); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0);
    chk("R4 nine: lo field", 1'b1, 16'hC095); chk_s("R4 nine: lo field", 16'hC015); nxt();
    lose_n(1100, 4'hA);
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R4 1100: hi", 1'b1, 16'h4000); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R4 1100: mid", 1'b1, 16'h8001); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R4 1100: lo", 1'b1, 16'hC4CA); nxt();
  endtask

  task automatic t_saturate();
    lose_n(70, 4'h6);
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk_s("R7 saturated hi", 16'h4003); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk_s("R7 saturated mid", 16'h8003); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0);
    chk_s("R7 saturated lo", 16'hC036); chk("R7 wide count 70", 1'b1, 16'hC466); nxt();
  endtask

  task automatic t_restart();
    lose_n(2, 4'h2);
    put(1'b1, 14'h0111, 4'h9, 1'b0, 1'b0); chk("R6 first word, sample lost", 1'b1, 16'h4000); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R6 restart at tag 01", 1'b1, 16'h4000); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b1, 1'b0); chk("R3 stall while full", 1'b0, 16'h0); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R3 tag 10 after stall", 1'b1, 16'h8000); nxt();
    put(1'b0, 14'h0, 4'h0, 1'b0, 1'b0); chk("R6 updated count 3 chan 9", 1'b1, 16'hC039); nxt();
  endtask

  task automatic t_stop();
    put(1'b1, 14'h0333, 4'h1, 1'b0, 1'b1); chk("R8 stop blocks write", 1'b0, 16'h0); nxt();
    for (int i = 0; i < 4; i++) begin
      put(1'b1, 14'h0444, 4'h2, 1'b1, 1'b1); nxt();
    end
    put(1'b1, 14'h0AAA, 4'h1, 1'b0, 1'b0); chk("R8 no loss counted under stop", 1'b1, 16'h0AAA); nxt();
    lose_n(1, 4'h3);
    put(1'b1, 14'h0, 4'h0, 1'b0, 1'b1); chk("R8 flush tag 01 under stop", 1'b1, 16'h4000); nxt();
    put(1'b1, 14'h0, 4'h0, 1'b0, 1'b1); chk("R8 flush tag 10 under stop", 1'b1, 16'h8000); nxt();
    put(1'b1, 14'h0, 4'h0, 1'b0, 1'b1); chk("R8 flush tag 11 under stop", 1'b1, 16'hC013); nxt();
    put(1'b1, 14'h0, 4'h0, 1'b0, 1'b1); chk("R8 quiet after flush", 1'b0, 16'h0); nxt();
  endtask

  initial begin
    rst_n = 1'b0;
    valid = 1'b0; stop = 1'b0; full = 1'b0; data = '0; chan = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pass();
    t_basic_gap();
    t_fields();
    t_saturate();
    t_restart();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got running, expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule